// File: doc/BRIEF.md
# Element step sequencer

This block walks the element and sub-element positions of one vectorised instruction. For every issued pair it presents a source position (element index plus sub-element index) and a destination position (element index plus sub-element index). The loop bounds are a vector length of 0 to 127 elements and a sub-vector length of 1 to 4. Each side picks its own nesting order. In the default order the element index is the outer loop and the sub-element index the inner one. In the swapped order the sub-element index is outer and the element index steps fastest. The two sides are independent, so a source walking element-outer can feed a destination walking sub-element-outer.

A start pulse captures the loop bounds and the two nesting selects, and loads both positions from resume inputs. A fresh loop loads zeros there; a loop that was interrupted loads its saved position. In horizontal mode the block then issues one pair per cycle until both sides have reached their final pair. It then pulses `done` and returns every index to zero. In vertical mode the current pair is held and presented as valid until a step request moves it on. A step request on the final pair wraps every index to zero and pulses `done`.

The control is a four-state machine:
- IDLE waits for `start`. It moves to FINISH if the vector length is zero, to PAUSE if vertical mode is selected, and to SWEEP otherwise.
- SWEEP advances every cycle and moves to FINISH on the cycle that issues the last pair.
- PAUSE holds until a step request arrives. A step request on the last pair moves it to FINISH.
- FINISH drives the one-cycle `done` and always returns to IDLE.

Top module: `elem_step_sequencer`

## Requirements
- R1: While reset is asserted and after its release with no start, `valid` and `done` are 0 and all four indices are 0.
- R2: A `start` sampled in IDLE loads the four indices from the resume inputs. With nonzero length and vertical mode clear, `valid` is 1 on the next cycle and shows that loaded pair.
- R3: With `src_sub_outer` = 0, the source order is element-outer: `src_sub` counts 0 to `sub_len_m1`, then wraps to 0 while `src_idx` increments.
- R4: With `src_sub_outer` = 1, the source order is sub-element-outer: `src_idx` counts 0 to length−1, then wraps to 0 while `src_sub` increments.
- R5: `dst_sub_outer` selects the destination order in the same way as R3/R4, independently of the source select.
- R6: In SWEEP each valid cycle shows the next pair in order. The cycle after the last valid pair has `done` = 1, `valid` = 0 and all indices 0.
- R7: A start with a vector length of 0 produces no valid cycle. `done` is 1 on the cycle right after the start.
- R8: In vertical mode, while `step_req` is 0, `valid` stays 1 and all four indices stay unchanged.
- R9: In vertical mode, a `step_req` while both sides are on their final pair gives `done` = 1, `valid` = 0 and all indices 0 on the next cycle. Any other `step_req` advances each side by one pair.
- R10: Resume values must lie within the loop bounds. A side that reaches its final pair before the other holds there while the other keeps advancing. The run ends when both sides are final.
- R11: `start` is ignored outside IDLE. A run in progress keeps its bounds, order and position.
- R12: The sub-vector length is `sub_len_m1`+1, from 1 to 4. While `valid` is 1, sub-element indices stay at or below `sub_len_m1` and element indices below the captured length, up to 127 elements.
- R13: `done` lasts exactly one cycle and is never 1 together with `valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop (sampled only in IDLE) |
| step_req | input | 1 | Advance request in vertical mode |
| vec_len | input | 7 | Number of elements |
| sub_len_m1 | input | 2 | Sub-vector length minus one |
| src_sub_outer | input | 1 | Source order: 1 = sub-element outer |
| dst_sub_outer | input | 1 | Destination order: 1 = sub-element outer |
| vert_mode | input | 1 | 1 = advance only on step request |
| resume_src | input | 7 | Starting source element index |
| resume_ssub | input | 2 | Starting source sub-element index |
| resume_dst | input | 7 | Starting destination element index |
| resume_dsub | input | 2 | Starting destination sub-element index |
| src_idx | output | 7 | Source element index |
| src_sub | output | 2 | Source sub-element index |
| dst_idx | output | 7 | Destination element index |
| dst_sub | output | 2 | Destination sub-element index |
| valid | output | 1 | Indices describe an issued pair |
| done | output | 1 | One-cycle end-of-loop pulse |

## Verification
The bench pairs opposite nesting orders on the two sides and sets a sub-vector length of 3 so the wrap points fall at uneven places. A design that shared one counter between the sides, or tied the destination order to the source select, then shows wrong destination pairs. It runs a zero-length loop, a single-pair loop and the 127×4 maximum, where an off-by-one in the last-pair compare would add or drop a cycle before `done`. A resumed run starts the two sides at different positions, which exposes a design that stops on the first side to finish or lets that side run past its final pair. Vertical-mode runs hold for several cycles between steps, and a stray `start` is issued mid-run; a design that drifted without a request, failed to wrap on the last step, or restarted on the stray pulse would emit pairs the scoreboard does not expect.

// File: rtl/elem_seq_pkg.sv
package elem_seq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_PAUSE  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    // Number of independent index sides (source, destination)
    localparam int NUM_SIDES = 2;
    localparam int SIDE_SRC  = 0;
    localparam int SIDE_DST  = 1;

endpackage

// File: rtl/elem_side_next.sv
// Combinational successor of one (element, sub-element) position.
module elem_side_next #(
    parameter int EW = 7,
    parameter int SW = 2
) (
    input  logic [EW-1:0] cur_elem,
    input  logic [SW-1:0] cur_sub,
    input  logic [EW-1:0] elem_last,
    input  logic [SW-1:0] sub_last,
    input  logic          sub_outer,
    output logic [EW-1:0] nxt_elem,
    output logic [SW-1:0] nxt_sub,
    output logic          at_last
);

    logic elem_wrap;
    logic sub_wrap;

    always_comb begin
        elem_wrap = (cur_elem == elem_last);
        sub_wrap  = (cur_sub == sub_last);
        at_last   = elem_wrap && sub_wrap;
        nxt_elem  = cur_elem;
        nxt_sub   = cur_sub;
        if (!sub_outer) begin
            // element outer, sub-element inner
            if (sub_wrap) begin
                nxt_sub  = '0;
                nxt_elem = cur_elem + EW'(1);
            end else begin
                nxt_sub  = cur_sub + SW'(1);
            end
        end else begin
            // sub-element outer, element inner
            if (elem_wrap) begin
                nxt_elem = '0;
                nxt_sub  = cur_sub + SW'(1);
            end else begin
                nxt_elem = cur_elem + EW'(1);
            end
        end
    end

endmodule

// File: rtl/elem_side_track.sv
// Position register for one side, saturating on its final pair.
module elem_side_track #(
    parameter int EW = 7,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clear,
    input  logic          advance,
    input  logic [EW-1:0] load_elem,
    input  logic [SW-1:0] load_sub,
    input  logic [EW-1:0] elem_last,
    input  logic [SW-1:0] sub_last,
    input  logic          sub_outer,
    output logic [EW-1:0] elem,
    output logic [SW-1:0] sub,
    output logic          at_last
);

    logic [EW-1:0] nxt_elem;
    logic [SW-1:0] nxt_sub;

    elem_side_next #(.EW(EW), .SW(SW)) u_next (
        .cur_elem  (elem),
        .cur_sub   (sub),
        .elem_last (elem_last),
        .sub_last  (sub_last),
        .sub_outer (sub_outer),
        .nxt_elem  (nxt_elem),
        .nxt_sub   (nxt_sub),
        .at_last   (at_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem <= '0;
            sub  <= '0;
        end else if (clear) begin
            elem <= '0;
            sub  <= '0;
        end else if (load) begin
            elem <= load_elem;
            sub  <= load_sub;
        end else if (advance && !at_last) begin
            elem <= nxt_elem;
            sub  <= nxt_sub;
        end
    end

    // R6: an advance on a non-final pair moves the position
    p_advance_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !at_last && !clear && !load) |=> ({elem, sub} != $past({elem, sub})));

    // R10: a side on its final pair holds while the other side runs
    p_final_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && at_last && !clear && !load) |=> $stable({elem, sub}));

endmodule

// File: rtl/elem_seq_ctrl.sv
// Loop controller: IDLE, SWEEP, PAUSE, FINISH.
module elem_seq_ctrl
    import elem_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       step_req,
    input  logic       len_zero,
    input  logic       vert_mode,
    input  logic       both_last,
    output seq_state_e state_q,
    output logic       capture,
    output logic       load,
    output logic       clear,
    output logic       advance,
    output logic       valid,
    output logic       done
);

    seq_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (len_zero) begin
                        state_d = ST_FINISH;
                    end else if (vert_mode) begin
                        state_d = ST_PAUSE;
                    end else begin
                        state_d = ST_SWEEP;
                    end
                end
            end
            ST_SWEEP: begin
                if (both_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_PAUSE: begin
                if (step_req && both_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        capture = 1'b0;
        load    = 1'b0;
        clear   = 1'b0;
        advance = 1'b0;
        valid   = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture = start;
                load    = start;
                clear   = start && len_zero;
            end
            ST_SWEEP: begin
                valid   = 1'b1;
                advance = 1'b1;
                clear   = both_last;
            end
            ST_PAUSE: begin
                valid   = 1'b1;
                advance = step_req;
                clear   = step_req && both_last;
            end
            ST_FINISH: begin
                done    = 1'b1;
            end
            default: begin
                valid   = 1'b0;
            end
        endcase
    end

    // R13: done is a single-cycle pulse
    p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: done never overlaps valid
    p_done_not_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && valid));

    // R8: vertical mode stays put without a step request
    p_pause_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && !step_req) |=> (state_q == ST_PAUSE));

endmodule

// File: rtl/elem_step_sequencer.sv
// Top: captures loop bounds and drives source and destination trackers.
module elem_step_sequencer
    import elem_seq_pkg::*;
#(
    parameter int EW = 7,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step_req,
    input  logic [EW-1:0] vec_len,
    input  logic [SW-1:0] sub_len_m1,
    input  logic          src_sub_outer,
    input  logic          dst_sub_outer,
    input  logic          vert_mode,
    input  logic [EW-1:0] resume_src,
    input  logic [SW-1:0] resume_ssub,
    input  logic [EW-1:0] resume_dst,
    input  logic [SW-1:0] resume_dsub,
    output logic [EW-1:0] src_idx,
    output logic [SW-1:0] src_sub,
    output logic [EW-1:0] dst_idx,
    output logic [SW-1:0] dst_sub,
    output logic          valid,
    output logic          done
);

    localparam int NS = NUM_SIDES;

    seq_state_e        state_q;
    logic              capture;
    logic              load;
    logic              clear;
    logic              advance;
    logic              both_last;
    logic              len_zero;

    logic [EW-1:0]     len_q;
    logic [SW-1:0]     sub_last_q;
    logic [NS-1:0]     outer_q;
    logic [EW-1:0]     elem_last;

    logic [EW-1:0]     init_e [NS];
    logic [SW-1:0]     init_s [NS];
    logic [EW-1:0]     cur_e  [NS];
    logic [SW-1:0]     cur_s  [NS];
    logic [NS-1:0]     side_last;

    assign len_zero  = (vec_len == '0);
    assign elem_last = len_q - EW'(1);
    assign both_last = &side_last;

    assign init_e[SIDE_SRC] = resume_src;
    assign init_s[SIDE_SRC] = resume_ssub;
    assign init_e[SIDE_DST] = resume_dst;
    assign init_s[SIDE_DST] = resume_dsub;

    // Loop bounds and nesting, captured on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q      <= '0;
            sub_last_q <= '0;
            outer_q    <= '0;
        end else if (capture) begin
            len_q      <= vec_len;
            sub_last_q <= sub_len_m1;
            outer_q    <= {dst_sub_outer, src_sub_outer};
        end
    end

    elem_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step_req  (step_req),
        .len_zero  (len_zero),
        .vert_mode (vert_mode),
        .both_last (both_last),
        .state_q   (state_q),
        .capture   (capture),
        .load      (load),
        .clear     (clear),
        .advance   (advance),
        .valid     (valid),
        .done      (done)
    );

    for (genvar g = 0; g < NS; g++) begin : g_side
        elem_side_track #(.EW(EW), .SW(SW)) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .clear     (clear),
            .advance   (advance),
            .load_elem (init_e[g]),
            .load_sub  (init_s[g]),
            .elem_last (elem_last),
            .sub_last  (sub_last_q),
            .sub_outer (outer_q[g]),
            .elem      (cur_e[g]),
            .sub       (cur_s[g]),
            .at_last   (side_last[g])
        );
    end

    assign src_idx = cur_e[SIDE_SRC];
    assign src_sub = cur_s[SIDE_SRC];
    assign dst_idx = cur_e[SIDE_DST];
    assign dst_sub = cur_s[SIDE_DST];

    // R7: zero length yields done at once, without a valid cycle
    p_zero_len_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && len_zero) |=> (done && !valid));

    // R9: every loop end leaves all indices at zero
    p_end_zeroed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (src_idx == '0 && src_sub == '0 && dst_idx == '0 && dst_sub == '0));

    // R8: paused indices do not drift
    p_pause_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && !step_req) |=>
            (valid && $stable(src_idx) && $stable(src_sub) && $stable(dst_idx) && $stable(dst_sub)));

    // R11: a start outside IDLE leaves the captured loop unchanged
    p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> ($stable(len_q) && $stable(sub_last_q) && $stable(outer_q)));

    // R12: issued sub-element indices stay within the sub-vector length
    p_sub_in_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (src_sub <= sub_last_q && dst_sub <= sub_last_q));

endmodule

// File: tb/elem_step_sequencer_bench.sv
module elem_step_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EW   = 7;
    localparam int SW   = 2;
    localparam int MAXP = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          step_req = 1'b0;
    logic [EW-1:0] vec_len = '0;
    logic [SW-1:0] sub_len_m1 = '0;
    logic          src_sub_outer = 1'b0;
    logic          dst_sub_outer = 1'b0;
    logic          vert_mode = 1'b0;
    logic [EW-1:0] resume_src = '0;
    logic [SW-1:0] resume_ssub = '0;
    logic [EW-1:0] resume_dst = '0;
    logic [SW-1:0] resume_dsub = '0;
    logic [EW-1:0] src_idx;
    logic [SW-1:0] src_sub;
    logic [EW-1:0] dst_idx;
    logic [SW-1:0] dst_sub;
    logic          valid;
    logic          done;

    typedef struct {
        bit    is_done;
        int    s;
        int    ss;
        int    d;
        int    ds;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    lst_e [2][MAXP];
    int    lst_s [2][MAXP];

    elem_step_sequencer u_elem_step_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .step_req      (step_req),
        .vec_len       (vec_len),
        .sub_len_m1    (sub_len_m1),
        .src_sub_outer (src_sub_outer),
        .dst_sub_outer (dst_sub_outer),
        .vert_mode     (vert_mode),
        .resume_src    (resume_src),
        .resume_ssub   (resume_ssub),
        .resume_dst    (resume_dst),
        .resume_dsub   (resume_dsub),
        .src_idx       (src_idx),
        .src_sub       (src_sub),
        .dst_idx       (dst_idx),
        .dst_sub       (dst_sub),
        .valid         (valid),
        .done          (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Ordered pair list of one side, built from the nesting rule (R3/R4/R5)
    function automatic int build(input int side, input int n_el, input int n_sub, input bit sub_outer);
        int k = 0;
        if (!sub_outer) begin
            for (int e = 0; e < n_el; e++)
                for (int s = 0; s < n_sub; s++) begin
                    lst_e[side][k] = e; lst_s[side][k] = s; k++;
                end
        end else begin
            for (int s = 0; s < n_sub; s++)
                for (int e = 0; e < n_el; e++) begin
                    lst_e[side][k] = e; lst_s[side][k] = s; k++;
                end
        end
        return k;
    endfunction

    function automatic int find_pos(input int side, input int cnt, input int e, input int s);
        for (int k = 0; k < cnt; k++)
            if (lst_e[side][k] == e && lst_s[side][k] == s) return k;
        return 0;
    endfunction

    task automatic push_exp(input bit dn, input int s, input int ss, input int d, input int ds, input string req);
        exp_t x;
        x.is_done = dn; x.s = s; x.ss = ss; x.d = d; x.ds = ds; x.req = req;
        exp_q.push_back(x);
    endtask

    task automatic push_pair(input int ps, input int pd, input string req);
        push_exp(1'b0, lst_e[0][ps], lst_s[0][ps], lst_e[1][pd], lst_s[1][pd], req);
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL %s missing outputs: actual=0 expected=%0d", exp_q[0].req, exp_q.size());
            exp_q.delete();
        end
    endtask

    // Monitor: pops one expected item per valid or done cycle
    initial begin
        forever begin
            exp_t x;
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && (valid || done)) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R6 unexpected output: actual valid=%0d done=%0d expected none", valid, done);
                end else begin
                    x = exp_q.pop_front();
                    check(x.req, "done",    int'(done),    int'(x.is_done));
                    check(x.req, "valid",   int'(valid),   int'(!x.is_done));
                    check(x.req, "src_idx", int'(src_idx), x.s);
                    check(x.req, "src_sub", int'(src_sub), x.ss);
                    check(x.req, "dst_idx", int'(dst_idx), x.d);
                    check(x.req, "dst_sub", int'(dst_sub), x.ds);
                end
            end
        end
    end

    // Horizontal run: expected pairs pushed before start (R2..R7, R10..R12)
    task automatic run_sweep(input int n_vl, input int n_sm1, input bit pk, input bit upk,
                             input int is_, input int iss, input int id, input int ids,
                             input string req, input bit poke);
        int cs, cd, ps, pd, n, a, b;
        if (n_vl == 0) begin
            push_exp(1'b1, 0, 0, 0, 0, req);
        end else begin
            cs = build(0, n_vl, n_sm1 + 1, pk);
            cd = build(1, n_vl, n_sm1 + 1, upk);
            ps = find_pos(0, cs, is_, iss);
            pd = find_pos(1, cd, id, ids);
            n  = ((cs - ps) > (cd - pd)) ? (cs - ps) : (cd - pd);
            for (int k = 0; k < n; k++) begin
                a = (ps + k < cs) ? ps + k : cs - 1;
                b = (pd + k < cd) ? pd + k : cd - 1;
                push_pair(a, b, (k == 0) ? "R2" : req);
            end
            push_exp(1'b1, 0, 0, 0, 0, "R6");
        end
        @(negedge clk);
        vec_len = EW'(n_vl); sub_len_m1 = SW'(n_sm1);
        src_sub_outer = pk; dst_sub_outer = upk; vert_mode = 1'b0;
        resume_src = EW'(is_); resume_ssub = SW'(iss);
        resume_dst = EW'(id);  resume_dsub = SW'(ids);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: stray start with other settings during the run
            @(negedge clk);
            vec_len = 7'd2; sub_len_m1 = 2'd3; src_sub_outer = ~pk;
            resume_src = 7'd1; resume_dst = 7'd1; vert_mode = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0; vert_mode = 1'b0;
        end
        wait_drain();
    endtask

    // Vertical run: expected item pushed each cycle (R8, R9, R11)
    task automatic run_vert(input int n_vl, input int n_sm1, input bit pk, input bit upk, input int gap);
        int cs, cd, ps, pd, cyc;
        bit fin;
        cs = build(0, n_vl, n_sm1 + 1, pk);
        cd = build(1, n_vl, n_sm1 + 1, upk);
        ps = 0; pd = 0; cyc = 0; fin = 1'b0;
        @(negedge clk);
        vec_len = EW'(n_vl); sub_len_m1 = SW'(n_sm1);
        src_sub_outer = pk; dst_sub_outer = upk; vert_mode = 1'b1;
        resume_src = '0; resume_ssub = '0; resume_dst = '0; resume_dsub = '0;
        push_pair(ps, pd, "R2");
        start = 1'b1;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            start = (cyc == 2);
            if (cyc == 2) vec_len = 7'd0;
            step_req = ((cyc % gap) == 0);
            if (step_req) begin
                if (ps == cs - 1 && pd == cd - 1) begin
                    push_exp(1'b1, 0, 0, 0, 0, "R9");
                    fin = 1'b1;
                end else begin
                    if (ps < cs - 1) ps++;
                    if (pd < cd - 1) pd++;
                    push_pair(ps, pd, (pk != upk) ? "R5" : "R9");
                end
            end else begin
                push_pair(ps, pd, (cyc == 2) ? "R11" : "R8");
            end
        end
        @(negedge clk);
        step_req = 1'b0; start = 1'b0; vert_mode = 1'b0;
        wait_drain();
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(valid), 0);
        check("R1", "done in reset",  int'(done), 0);
        check("R1", "indices in reset", int'({src_idx, src_sub, dst_idx, dst_sub}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "valid after reset", int'(valid), 0);
        check("R1", "indices after reset", int'({src_idx, src_sub, dst_idx, dst_sub}), 0);

        // R6: plain sweep, sub-vector length 1
        run_sweep(5, 0, 1'b0, 1'b0, 0, 0, 0, 0, "R6", 1'b0);
        // R3 + R5: source element-outer, destination sub-element-outer, length 3
        run_sweep(3, 2, 1'b0, 1'b1, 0, 0, 0, 0, "R3", 1'b0);
        // R4: source sub-element-outer
        run_sweep(4, 1, 1'b1, 1'b0, 0, 0, 0, 0, "R4", 1'b0);
        // R12: sub-vector length 4, both swapped
        run_sweep(2, 3, 1'b1, 1'b1, 0, 0, 0, 0, "R12", 1'b0);
        // R7: zero length
        run_sweep(0, 1, 1'b0, 1'b0, 0, 0, 0, 0, "R7", 1'b0);
        // R6: single pair
        run_sweep(1, 0, 1'b0, 1'b0, 0, 0, 0, 0, "R6", 1'b0);
        // R10: resumed positions differ per side
        run_sweep(6, 1, 1'b0, 1'b1, 4, 1, 2, 0, "R10", 1'b0);
        // R11: stray start mid-run
        run_sweep(8, 0, 1'b0, 1'b0, 0, 0, 0, 0, "R11", 1'b1);
        // R12: maximum length and sub-vector length
        run_sweep(127, 3, 1'b0, 1'b1, 0, 0, 0, 0, "R12", 1'b0);
        // R8/R9: vertical mode with holds
        run_vert(3, 1, 1'b0, 1'b0, 3);
        run_vert(2, 2, 1'b1, 1'b0, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule